// File: doc/BRIEF.md
# Dual-Channel Timed Overcurrent Latch-Off Controller

This block is the digital sequencer of a two-channel protected load switch. Each channel has an enable input and an overcurrent flag from an external current comparator. Both channels share a supply-good flag and an over-temperature flag. For each channel the block drives a switch-on command, a ramp-up request for the soft-start driver, a shutdown-speed select and a latched fault indication. The fault indication is active low and carries an output-enable that models an open-drain pin.

After a valid enable with good supply, a channel ramps up while fault reporting is blanked for one timeout window. It then runs normally. An overcurrent moves the channel into current regulation and starts a timer of the same length. If the overcurrent outlasts the window, the channel is latched off and reports one fault. Only an enable release or loss of supply clears that fault. All timing is in clock cycles: the window length is the clock rate multiplied by the window time, and both are parameters.

Top module: `ocp_latchoff_ctrl`

## Requirements
- R1: While reset is asserted, every sw_on_o, ramp_up_o and fast_off_o bit is 0 and every fault_no bit is 1.
- R2: When the enable becomes active with supply good and no over-temperature, sw_on_o and ramp_up_o rise after the 3rd clock edge. ramp_up_o stays high for exactly TMO cycles (TMO = CLK_KHZ*WINDOW_US/1000) and then falls while sw_on_o stays high.
- R3: An overcurrent present from the start of turn-on raises no fault during the ramp-up window. Timing starts only when the window ends, so the fault falls at edge 2*TMO+4 after enable.
- R4: With a channel in normal on state, an overcurrent held continuously makes fault_no low and sw_on_o low at clock edge TMO+3 after the flag rises, and not before.
- R5: An overcurrent that clears before expiry returns the channel to normal on with the timer cleared. A later overcurrent needs the full TMO+3 edges to latch.
- R6: A latched fault stays low while enable stays active, whatever the overcurrent flag does, so there is only one fault event. It returns high at the 3rd edge after the enable goes inactive.
- R7: When supply_ok_i is low, fault_oe_o is 0 at once. At the next edge all channels are off and the fault latches are cleared. When supply returns with the enable still active, the channels restart through ramp-up.
- R8: fast_off_o is 0 after a disable from the ramp-up or normal on state. It is 1 after a disable during current regulation, after a latch-off, and after an over-temperature shutdown.
- R9: While overtemp_i is high, both channels are off from the next edge with fast_off_o = 1 and no fault raised. After it clears, an enabled channel restarts ramp-up at the next edge.
- R10: The channels are independent: a latch-off on one leaves the other channel's switch and fault unchanged.
- R11: Parameter EN_ACT_HIGH selects the enable polarity: 1 means a high level enables, 0 means a low level enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | N_CH | Per-channel enable, polarity set by EN_ACT_HIGH, asynchronous |
| oc_i | input | N_CH | Per-channel overcurrent flag from the comparator, asynchronous |
| supply_ok_i | input | 1 | Shared supply-good flag, synchronous |
| overtemp_i | input | 1 | Shared over-temperature flag, synchronous |
| sw_on_o | output | N_CH | Switch-on command per channel |
| ramp_up_o | output | N_CH | Soft-start ramp request, high during the start-up window |
| fast_off_o | output | N_CH | Shutdown speed select: 1 fast pulldown, 0 slow ramp |
| fault_no | output | N_CH | Latched fault, active low |
| fault_oe_o | output | N_CH | Fault pin drive enable, 0 means released (high impedance) |

## Verification
A channel stuck in the wrong internal state shows at the ports within one window at most. A timer that is not cleared on an overcurrent dropout makes the second latch-off come early, and the bench catches this to the exact edge. A missing start-up blank moves the fault edge a full TMO earlier. A wrong shutdown branch shows as a fast_off_o value three edges after a disable. Coupling between channels shows as a dropped switch or fault on the neighbour in the same cycle as the latch-off.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [2:0] {
    CH_OFF,
    CH_BLANK,
    CH_ON,
    CH_REG,
    CH_LATCH
  } ch_state_e;
endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
  parameter int unsigned    W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ocp_timer.sv
module ocp_timer #(
  parameter int unsigned LIMIT = 600000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (run_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ocp_channel.sv
module ocp_channel
  import ocp_pkg::*;
#(
  parameter int unsigned TMO = 600000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,        // synchronised, active high
  input  logic oc_i,        // synchronised
  input  logic supply_ok_i,
  input  logic overtemp_i,
  output logic sw_on_o,
  output logic ramp_up_o,
  output logic fast_off_o,
  output logic fault_o
);
  ch_state_e st_q, st_d;
  logic      fast_q, fast_d;
  logic      tmr_run, tmr_clr, tmr_done;

  // one window timer serves both start-up blanking and regulation
  assign tmr_run = (st_q == CH_BLANK) || (st_q == CH_REG);
  assign tmr_clr = !tmr_run || ((st_q == CH_REG) && !oc_i);

  ocp_timer #(.LIMIT(TMO)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .run_i  (tmr_run),
    .done_o (tmr_done)
  );

  always_comb begin
    st_d   = st_q;
    fast_d = fast_q;
    if (!supply_ok_i) begin
      st_d = CH_OFF;
      if (st_q != CH_OFF) fast_d = 1'b1;
    end else begin
      unique case (st_q)
        CH_OFF: if (en_i && !overtemp_i) st_d = CH_BLANK;
        CH_BLANK: begin
          if (overtemp_i)    begin st_d = CH_OFF; fast_d = 1'b1; end
          else if (!en_i)    begin st_d = CH_OFF; fast_d = 1'b0; end
          else if (tmr_done) st_d = CH_ON;
        end
        CH_ON: begin
          if (overtemp_i)    begin st_d = CH_OFF; fast_d = 1'b1; end
          else if (!en_i)    begin st_d = CH_OFF; fast_d = 1'b0; end
          else if (oc_i)     st_d = CH_REG;
        end
        CH_REG: begin
          if (overtemp_i || !en_i) begin st_d = CH_OFF; fast_d = 1'b1; end
          else if (!oc_i)    st_d = CH_ON;
          else if (tmr_done) begin st_d = CH_LATCH; fast_d = 1'b1; end
        end
        CH_LATCH: if (!en_i) st_d = CH_OFF;
        default: st_d = CH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CH_OFF;
      fast_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      fast_q <= fast_d;
    end
  end

  assign sw_on_o    = (st_q == CH_BLANK) || (st_q == CH_ON) || (st_q == CH_REG);
  assign ramp_up_o  = (st_q == CH_BLANK);
  assign fast_off_o = fast_q;
  assign fault_o    = (st_q == CH_LATCH);
endmodule

// File: rtl/ocp_latchoff_ctrl.sv
module ocp_latchoff_ctrl #(
  parameter int unsigned N_CH        = 2,
  parameter int unsigned CLK_KHZ     = 50000,
  parameter int unsigned WINDOW_US   = 12000,
  parameter bit          EN_ACT_HIGH = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] en_i,
  input  logic [N_CH-1:0] oc_i,
  input  logic            supply_ok_i,
  input  logic            overtemp_i,
  output logic [N_CH-1:0] sw_on_o,
  output logic [N_CH-1:0] ramp_up_o,
  output logic [N_CH-1:0] fast_off_o,
  output logic [N_CH-1:0] fault_no,
  output logic [N_CH-1:0] fault_oe_o
);
  localparam longint unsigned TMO_L = (longint'(CLK_KHZ) * longint'(WINDOW_US)) / 1000;
  localparam int unsigned TMO = (TMO_L < 2) ? 2 : int'(TMO_L);
  localparam logic [N_CH-1:0] EN_IDLE = EN_ACT_HIGH ? {N_CH{1'b0}} : {N_CH{1'b1}};

  logic [N_CH-1:0] en_s, oc_s, en_act, fault;

  ocp_sync #(.W(N_CH), .RST_VAL(EN_IDLE)) u_en_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (en_i), .q_o (en_s)
  );

  ocp_sync #(.W(N_CH), .RST_VAL('0)) u_oc_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (oc_i), .q_o (oc_s)
  );

  if (EN_ACT_HIGH) begin : g_en_hi
    assign en_act = en_s;
  end else begin : g_en_lo
    assign en_act = ~en_s;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ocp_channel #(.TMO(TMO)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en_act[c]),
      .oc_i        (oc_s[c]),
      .supply_ok_i (supply_ok_i),
      .overtemp_i  (overtemp_i),
      .sw_on_o     (sw_on_o[c]),
      .ramp_up_o   (ramp_up_o[c]),
      .fast_off_o  (fast_off_o[c]),
      .fault_o     (fault[c])
    );
  end

  assign fault_no   = ~fault;
  assign fault_oe_o = {N_CH{supply_ok_i}};
endmodule

// File: rtl/ocp_latchoff_ctrl_chk.sv
module ocp_latchoff_ctrl_chk #(
  parameter int unsigned N_CH        = 2,
  parameter bit          EN_ACT_HIGH = 1'b1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] en_i,
  input logic            supply_ok_i,
  input logic            overtemp_i,
  input logic [N_CH-1:0] sw_on_o,
  input logic [N_CH-1:0] ramp_up_o,
  input logic [N_CH-1:0] fast_off_o,
  input logic [N_CH-1:0] fault_no
);
  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    p_fault_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fault_no[g] |-> !sw_on_o[g]);
    p_ramp_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ramp_up_o[g] |-> sw_on_o[g]);
    p_latch_fast_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fault_no[g] |-> fast_off_o[g]);
    p_fault_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fault_no[g]) |->
        (!$past(supply_ok_i) || ($past(en_i[g], 3) != EN_ACT_HIGH)));
  end

  p_supply_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (sw_on_o == '0) && (fault_no == '1));

  p_overtemp_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overtemp_i |=> (sw_on_o == '0) && ((fault_no | ~$past(fault_no)) == '1));
endmodule

bind ocp_latchoff_ctrl ocp_latchoff_ctrl_chk #(
  .N_CH(N_CH), .EN_ACT_HIGH(EN_ACT_HIGH)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .supply_ok_i (supply_ok_i),
  .overtemp_i  (overtemp_i),
  .sw_on_o     (sw_on_o),
  .ramp_up_o   (ramp_up_o),
  .fast_off_o  (fast_off_o),
  .fault_no    (fault_no)
);

// File: tb/ocp_latchoff_ctrl_tb.sv
module ocp_latchoff_ctrl_tb;
  localparam int TMO = 50; // 50000 kHz * 1 us / 1000

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] en = 2'b00, en_l = 2'b11, oc = 2'b00;
  logic supply_ok = 1'b1, ot = 1'b0;
  logic [1:0] sw_on, ramp, fast, fault_n, oe;
  logic [1:0] sw_on_l, ramp_l, fast_l, fault_n_l, oe_l;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ocp_latchoff_ctrl #(.N_CH(2), .CLK_KHZ(50000), .WINDOW_US(1), .EN_ACT_HIGH(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .oc_i(oc), .supply_ok_i(supply_ok),
    .overtemp_i(ot), .sw_on_o(sw_on), .ramp_up_o(ramp), .fast_off_o(fast),
    .fault_no(fault_n), .fault_oe_o(oe)
  );

  ocp_latchoff_ctrl #(.N_CH(2), .CLK_KHZ(50000), .WINDOW_US(1), .EN_ACT_HIGH(1'b0)) u_dut_low (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_l), .oc_i(oc), .supply_ok_i(supply_ok),
    .overtemp_i(ot), .sw_on_o(sw_on_l), .ramp_up_o(ramp_l), .fast_off_o(fast_l),
    .fault_no(fault_n_l), .fault_oe_o(oe_l)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic idle();
    en = 2'b00; oc = 2'b00; ot = 1'b0; supply_ok = 1'b1;
    tick(5);
  endtask

  task automatic bring_on(logic [1:0] m);
    en = en | m;
    tick(TMO + 4);
  endtask

  task automatic t_reset();
    chk("R1 sw_on", sw_on, 0);
    chk("R1 ramp", ramp, 0);
    chk("R1 fast", fast, 0);
    chk("R1 fault_n", fault_n, 2'b11);
  endtask

  task automatic t_turn_on();
    idle();
    en[0] = 1'b1;
    tick(2); chk("R2 still off", sw_on[0], 0);
    tick(1); chk("R2 sw_on", sw_on[0], 1); chk("R2 ramp", ramp[0], 1);
    tick(TMO - 1); chk("R2 ramp held", ramp[0], 1);
    tick(1); chk("R2 ramp end", ramp[0], 0); chk("R2 stays on", sw_on[0], 1);
  endtask

  task automatic t_timeout_and_hold();
    idle();
    bring_on(2'b01);
    oc[0] = 1'b1;
    tick(TMO + 2);
    chk("R4 no early fault", fault_n[0], 1); chk("R4 on before", sw_on[0], 1);
    tick(1);
    chk("R4 fault", fault_n[0], 0); chk("R4 off", sw_on[0], 0);
    chk("R8 latch fast", fast[0], 1);
    begin
      int hi = 0;
      for (int i = 0; i < 3 * TMO; i++) begin
        oc[0] = i[2];
        tick(1);
        if (fault_n[0]) hi++;
      end
      chk("R6 single fault", hi, 0);
    end
    oc[0] = 1'b0; en[0] = 1'b0;
    tick(2); chk("R6 held until release", fault_n[0], 0);
    tick(1); chk("R6 cleared", fault_n[0], 1);
  endtask

  task automatic t_retry();
    idle();
    bring_on(2'b01);
    oc[0] = 1'b1; tick(TMO / 2);
    oc[0] = 1'b0; tick(6);
    chk("R5 back on", sw_on[0], 1); chk("R5 no fault", fault_n[0], 1);
    oc[0] = 1'b1;
    tick(TMO + 2); chk("R5 full count", fault_n[0], 1);
    tick(1); chk("R5 latch", fault_n[0], 0);
  endtask

  task automatic t_blank();
    idle();
    en[0] = 1'b1; oc[0] = 1'b1;
    tick(TMO + 3);
    chk("R3 blanked", fault_n[0], 1); chk("R3 ramp done", ramp[0], 0);
    tick(TMO);
    chk("R3 timing after blank", fault_n[0], 1);
    tick(1);
    chk("R3 latch", fault_n[0], 0);
  endtask

  task automatic t_shutdown();
    idle();
    bring_on(2'b01);
    en[0] = 1'b0; tick(3);
    chk("R8 slow off", sw_on[0], 0); chk("R8 slow mode", fast[0], 0);
    bring_on(2'b01);
    oc[0] = 1'b1; tick(5);
    chk("R8 in regulation", sw_on[0], 1);
    en[0] = 1'b0; tick(3);
    chk("R8 fast off", sw_on[0], 0); chk("R8 fast mode", fast[0], 1);
  endtask

  task automatic t_supply();
    idle();
    bring_on(2'b11);
    oc[1] = 1'b1; tick(TMO + 3);
    chk("R7 ch1 latched", fault_n, 2'b01);
    supply_ok = 1'b0; oc[1] = 1'b0; #1;
    chk("R7 released", oe, 2'b00);
    tick(1);
    chk("R7 all off", sw_on, 0); chk("R7 faults cleared", fault_n, 2'b11);
    supply_ok = 1'b1; tick(1);
    chk("R7 restart", sw_on, 2'b11); chk("R7 restart ramp", ramp, 2'b11);
    chk("R7 drive back", oe, 2'b11);
  endtask

  task automatic t_overtemp();
    idle();
    bring_on(2'b11);
    ot = 1'b1; tick(1);
    chk("R9 off", sw_on, 0); chk("R9 fast", fast, 2'b11);
    tick(2 * TMO);
    chk("R9 no fault", fault_n, 2'b11);
    ot = 1'b0; tick(1);
    chk("R9 resume", sw_on, 2'b11); chk("R9 ramp", ramp, 2'b11);
  endtask

  task automatic t_indep();
    idle();
    bring_on(2'b11);
    oc[0] = 1'b1; tick(TMO + 3);
    chk("R10 ch0 latched", fault_n[0], 0);
    chk("R10 ch1 on", sw_on[1], 1); chk("R10 ch1 no fault", fault_n[1], 1);
    chk("R10 ch1 normal", ramp[1], 0);
  endtask

  task automatic t_polarity();
    chk("R11 low idle", sw_on_l, 0);
    en_l[0] = 1'b0; tick(3);
    chk("R11 low enables", sw_on_l, 2'b01);
    en_l = 2'b11; tick(3);
    chk("R11 high disables", sw_on_l, 0);
  endtask

  initial begin
    #25; t_reset();
    rst_n = 1'b1;
    tick(2);
    t_polarity();
    t_turn_on();
    t_timeout_and_hold();
    t_retry();
    t_blank();
    t_shutdown();
    t_supply();
    t_overtemp();
    t_indep();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule